// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This block is a pair of independent event counters placed on a simple register bus. Each counter has a control register. The control register selects one event by a sparse 6-bit code, starts or stops counting, and can request a clear. The accumulated count is read as a high half and a low half. The surrounding core supplies one-cycle event strobes, such as operand accesses, cache misses, branches, executed instructions, interrupts and pipeline freezes. The block also has an internal time base that divides the core clock to give an elapsed-time event.

Software programs a counter by writing its control register with the run bit and an event code. It reads the count registers at any time and stops the counter by writing the control register with the run bit low. A clear takes effect only on a counter that was already stopped. This rule means that an increment and a clear never compete for the same counter.

Top module: `perf_event_monitor`

## Requirements
- R1: After reset every register offset reads zero: both counters are stopped, with event code 0, count 0 and the overflow flag clear.
- R2: A control write with bit 15 set starts the counter with the event code taken from write data bits 5:0, and the count is kept. A control read returns the run state in bit 15, the overflow flag in bit 14 and the active code in bits 5:0, with all other bits zero.
- R3: A control write with bit 15 clear stops the counter and sets its active code to 0. The count is kept, and no further events are counted.
- R4: A control write with bit 13 set zeroes the count and the overflow flag only if that counter was stopped before the write. The same bit has no effect on a running counter.
- R5: The event codes map to `event_in` bits as follows: 0x01 to bit 0, 0x02 to bit 1, 0x08 to bit 2, 0x10 to bit 3, 0x11 to bit 4, 0x13 to bit 5, 0x16 to bit 6, 0x24 to bit 7 and 0x25 to bit 8. A running counter adds one for each clock cycle in which its selected bit is high. Other bits have no effect on it.
- R6: Code 0x23 counts elapsed time. The count adds one per time-base tick, and a tick comes once every TB_DIV core clocks.
- R7: Every code not listed in R5 or R6 counts nothing, whatever the event inputs do.
- R8: Register offsets come from the low 5 address bits, and higher address bits are ignored. The map is:
  - 0x04: control A
  - 0x08: control B
  - 0x0C: high count A
  - 0x10: low count A
  - 0x14: high count B
  - 0x18: low count B

  A high read returns count bits CNT_W-1:LO_W, zero-extended. With the defaults this is bits 47:32 in bits 15:0. A low read returns count bits LO_W-1:0. Offset 0 and all unlisted offsets read zero.
- R9: Bus writes to the count offsets, or to offset 0, change no register.
- R10: An increment from all ones wraps the count to zero and sets the sticky overflow flag, which is read in control bit 14. Only an accepted clear resets the flag.
- R11: The two counters are independent. Writing or counting on one never changes the other.
- R12: A control write takes effect at the clock edge on which it is written. An event present at that same edge is judged by the state before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Register address; only bits 4:0 are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| event_in | input | 9 | One-cycle event strobes, bit assignment as in R5 |

## Verification
The hardest situation to reach is the wrap of the count with its sticky overflow flag, because the full count width cannot be filled from the ports in a reasonable time. The bench therefore builds a small configuration with a 12-bit count split 4/8 between the high and low registers. It then holds one event high for exactly 4095 cycles, checks the all-ones value in both halves, and drives the single step that follows. A second delicate case is the edge on which a control write and an event coincide. The bench holds an event through both the start and the stop writes and expects exactly one count per edge that lies between them.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;

  localparam int NUM_CNT = 2;
  localparam int NUM_EVT = 9;

  // event codes; the strobe index order below is the event_in bit order
  localparam logic [5:0] EC_OPER_RD   = 6'h01;
  localparam logic [5:0] EC_OPER_WR   = 6'h02;
  localparam logic [5:0] EC_IC_MISS   = 6'h08;
  localparam logic [5:0] EC_BRANCH    = 6'h10;
  localparam logic [5:0] EC_BR_TAKEN  = 6'h11;
  localparam logic [5:0] EC_INSN_EXEC = 6'h13;
  localparam logic [5:0] EC_IRQ       = 6'h16;
  localparam logic [5:0] EC_ELAPSED   = 6'h23;
  localparam logic [5:0] EC_FRZ_IC    = 6'h24;
  localparam logic [5:0] EC_FRZ_DC    = 6'h25;

  localparam int CTL_RUN = 15;
  localparam int CTL_OVF = 14;
  localparam int CTL_CLR = 13;

  typedef enum logic [2:0] {
    RSEL_NONE, RSEL_CTL_A, RSEL_CTL_B,
    RSEL_HI_A, RSEL_LO_A, RSEL_HI_B, RSEL_LO_B
  } reg_sel_e;

  function automatic logic [5:0] strobe_code(input int idx);
    case (idx)
      0:       strobe_code = EC_OPER_RD;
      1:       strobe_code = EC_OPER_WR;
      2:       strobe_code = EC_IC_MISS;
      3:       strobe_code = EC_BRANCH;
      4:       strobe_code = EC_BR_TAKEN;
      5:       strobe_code = EC_INSN_EXEC;
      6:       strobe_code = EC_IRQ;
      7:       strobe_code = EC_FRZ_IC;
      default: strobe_code = EC_FRZ_DC;
    endcase
  endfunction

  function automatic reg_sel_e decode_offset(input logic [4:0] off);
    case (off)
      5'h04:   decode_offset = RSEL_CTL_A;
      5'h08:   decode_offset = RSEL_CTL_B;
      5'h0C:   decode_offset = RSEL_HI_A;
      5'h10:   decode_offset = RSEL_LO_A;
      5'h14:   decode_offset = RSEL_HI_B;
      5'h18:   decode_offset = RSEL_LO_B;
      default: decode_offset = RSEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/perfmon_rst_sync.sv
module perfmon_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/perfmon_timebase.sv
module perfmon_timebase #(
  parameter int TB_DIV = 4
) (
  input  logic clk,
  input  logic rst_ni,
  output logic tick
);
  generate
    if (TB_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int TW = $clog2(TB_DIV);
      localparam logic [TW-1:0] LAST = TW'(TB_DIV - 1);
      logic [TW-1:0] div_q, div_d;

      always_comb begin
        div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
      end

      assign tick = (div_q == LAST);

      // R6: ticks are isolated pulses when the ratio exceeds one
      assert_tick_isolated_R6: assert property (@(posedge clk) disable iff (!rst_ni)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/perfmon_event_sel.sv
module perfmon_event_sel
  import perfmon_pkg::*;
(
  input  logic [5:0]         code,
  input  logic [NUM_EVT-1:0] event_in,
  input  logic               tick,
  output logic               hit
);
  logic [NUM_EVT-1:0] match;

  generate
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_match
      assign match[i] = event_in[i] && (code == strobe_code(i));
    end
  endgenerate

  assign hit = (|match) || (tick && (code == EC_ELAPSED));
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter
  import perfmon_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             ctl_we,
  input  logic [31:0]      ctl_wdata,
  input  logic             hit,
  output logic             run,
  output logic             ovf,
  output logic [5:0]       code,
  output logic [CNT_W-1:0] count
);
  logic             run_q, run_d;
  logic             ovf_q, ovf_d;
  logic [5:0]       code_q, code_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             inc, clr_ok, wrap, cnt_en, ovf_en;

  always_comb begin
    inc    = run_q && hit;
    wrap   = inc && (&cnt_q);
    clr_ok = ctl_we && ctl_wdata[CTL_CLR] && !run_q;
    run_d  = run_q;
    code_d = code_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    if (inc)  cnt_d = cnt_q + 1'b1;
    if (wrap) ovf_d = 1'b1;
    if (ctl_we) begin
      if (ctl_wdata[CTL_RUN]) begin
        run_d  = 1'b1;
        code_d = ctl_wdata[5:0];
      end else begin
        run_d  = 1'b0;
        code_d = '0;
      end
    end
    if (clr_ok) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end
    cnt_en = inc || clr_ok;
    ovf_en = wrap || clr_ok;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      code_q <= '0;
    end else if (ctl_we) begin
      run_q  <= run_d;
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     ovf_q <= 1'b0;
    else if (ovf_en) ovf_q <= ovf_d;
  end

  assign run   = run_q;
  assign ovf   = ovf_q;
  assign code  = code_q;
  assign count = cnt_q;

  assert_clear_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_we && ctl_wdata[CTL_CLR] && !run_q) |=> (cnt_q == '0 && !ovf_q));

  assert_clear_ignored_running_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_we && ctl_wdata[CTL_CLR] && run_q && !hit) |=> $stable(cnt_q));

  assert_stop_clears_code_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_we && !ctl_wdata[CTL_RUN]) |=> (!run_q && code_q == '0));

  assert_stopped_holds_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!run_q && !ctl_we) |=> $stable(cnt_q));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(cnt_q) |-> (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (ovf_q && !(ctl_we && ctl_wdata[CTL_CLR])) |=> ovf_q);
endmodule

// File: rtl/perf_event_monitor.sv
module perf_event_monitor
  import perfmon_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 48,
  parameter int LO_W   = 32,
  parameter int TB_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [8:0]        event_in
);
  localparam int HI_W = CNT_W - LO_W;

  logic             rst_ni;
  logic             tick;
  reg_sel_e         sel;
  logic [NUM_CNT-1:0] ctl_we, run, ovf, hit;
  logic [5:0]       code  [NUM_CNT];
  logic [CNT_W-1:0] count [NUM_CNT];
  logic [31:0]      ctl_view [NUM_CNT];
  logic [31:0]      hi_view  [NUM_CNT];
  logic [31:0]      lo_view  [NUM_CNT];

  perfmon_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  perfmon_timebase #(.TB_DIV(TB_DIV)) u_tb (
    .clk    (clk),
    .rst_ni (rst_ni),
    .tick   (tick)
  );

  assign sel = decode_offset(bus_addr[4:0]);

  generate
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      localparam reg_sel_e MY_CTL = (g == 0) ? RSEL_CTL_A : RSEL_CTL_B;

      assign ctl_we[g] = bus_wr && (sel == MY_CTL);

      perfmon_event_sel u_sel (
        .code     (code[g]),
        .event_in (event_in),
        .tick     (tick),
        .hit      (hit[g])
      );

      perfmon_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_ni    (rst_ni),
        .ctl_we    (ctl_we[g]),
        .ctl_wdata (bus_wdata),
        .hit       (hit[g]),
        .run       (run[g]),
        .ovf       (ovf[g]),
        .code      (code[g]),
        .count     (count[g])
      );

      assign ctl_view[g] = {16'h0000, run[g], ovf[g], 8'h00, code[g]};
      assign hi_view[g]  = 32'(count[g][CNT_W-1:LO_W]);
      assign lo_view[g]  = 32'(count[g][LO_W-1:0]);
    end
  endgenerate

  always_comb begin
    case (sel)
      RSEL_CTL_A: bus_rdata = ctl_view[0];
      RSEL_CTL_B: bus_rdata = ctl_view[1];
      RSEL_HI_A:  bus_rdata = hi_view[0];
      RSEL_LO_A:  bus_rdata = lo_view[0];
      RSEL_HI_B:  bus_rdata = hi_view[1];
      RSEL_LO_B:  bus_rdata = lo_view[1];
      default:    bus_rdata = 32'h0;
    endcase
  end

  initial begin
    assert_split_widths_R8: assert (HI_W >= 1 && HI_W <= 32 && LO_W >= 1 && LO_W <= 32);
  end

  assert_offset_zero_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_addr[4:0] == 5'h00) |-> (bus_rdata == 32'h0));

  assert_ctl_write_isolated_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctl_we[0] && !run[1]) |=> $stable(count[1]));

  assert_cnt_write_no_ctl_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && sel != RSEL_CTL_A && sel != RSEL_CTL_B) |=> ($stable(run) && $stable(code[0]) && $stable(code[1])));
endmodule

// File: tb/perf_event_monitor_test.sv
module perf_event_monitor_test;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 12;
  localparam int LO_W   = 8;
  localparam int TB_DIV = 3;

  localparam logic [7:0] O_CTL_A = 8'h04, O_CTL_B = 8'h08;
  localparam logic [7:0] O_HI_A = 8'h0C, O_LO_A = 8'h10;
  localparam logic [7:0] O_HI_B = 8'h14, O_LO_B = 8'h18;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [8:0]        event_in;

  int total = 0;
  int bad   = 0;

  logic [5:0] code_of [9] = '{6'h01, 6'h02, 6'h08, 6'h10, 6'h11, 6'h13, 6'h16, 6'h24, 6'h25};

  always #4 clk = ~clk;

  perf_event_monitor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LO_W(LO_W), .TB_DIV(TB_DIV)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .event_in  (event_in)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic hold(input logic [8:0] pat, input int n);
    event_in = pat;
    repeat (n) @(negedge clk);
    event_in = '0;
  endtask

  function automatic bit is_assigned(input int c);
    for (int k = 0; k < 9; k++) if (c == int'(code_of[k])) return 1'b1;
    return (c == 'h23);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; event_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state on every offset
    for (int o = 0; o < 32; o += 4) begin
      rd(8'(o), v); chk("R1 reset read", v, 32'h0);
    end

    // R5 / R2 / R3: each assigned code against every strobe bit
    for (int i = 0; i < 9; i++) begin
      wr(O_CTL_A, 32'h0000_2000);
      wr(O_CTL_A, 32'h0000_8000 | 32'(code_of[i]));
      rd(O_CTL_A, v); chk("R2 ctl readback", v, 32'h8000 | 32'(code_of[i]));
      hold(~(9'd1 << i), 4);
      for (int j = 0; j < 9; j++) hold(9'd1 << j, j + 1);
      wr(O_CTL_A, 32'h0000_0000);
      rd(O_CTL_A, v); chk("R3 stopped ctl", v, 32'h0);
      rd(O_LO_A, v);  chk("R5 code count", v, 32'(i + 1));
      hold(9'h1FF, 3);
      rd(O_LO_A, v);  chk("R3 count kept after stop", v, 32'(i + 1));
    end

    // R7: every unassigned code counts nothing
    for (int c = 0; c < 64; c++) begin
      if (!is_assigned(c)) begin
        wr(O_CTL_A, 32'h0000_2000);
        wr(O_CTL_A, 32'h0000_8000 | 32'(c));
        hold(9'h1FF, 2 * TB_DIV);
        wr(O_CTL_A, 32'h0);
        rd(O_LO_A, v); chk("R7 unassigned code", v, 32'h0);
      end
    end

    // R6: elapsed time, window of M+2 edges
    for (int n = 5; n <= 9; n += 4) begin
      wr(O_CTL_B, 32'h0000_2000);
      wr(O_CTL_B, 32'h0000_8023);
      repeat (n * TB_DIV - 2) @(negedge clk);
      wr(O_CTL_B, 32'h0);
      rd(O_LO_B, v); chk("R6 elapsed ticks", v, 32'(n));
    end

    // R11: two counters on different events at once
    wr(O_CTL_A, 32'h0000_2000);
    wr(O_CTL_B, 32'h0000_2000);
    wr(O_CTL_A, 32'h0000_8010);
    wr(O_CTL_B, 32'h0000_8013);
    hold(9'b000001000, 4);
    hold(9'b000100000, 6);
    hold(9'b000101000, 3);
    wr(O_CTL_A, 32'h0);
    wr(O_CTL_B, 32'h0);
    rd(O_LO_A, v); chk("R11 counter A", v, 32'd7);
    rd(O_LO_B, v); chk("R11 counter B", v, 32'd9);
    wr(O_CTL_A, 32'h0000_2000);
    rd(O_LO_B, v); chk("R11 clear A leaves B", v, 32'd9);

    // R12: event held across start and stop writes
    event_in = 9'b1;
    wr(O_CTL_A, 32'h0000_8001);
    repeat (3) @(negedge clk);
    wr(O_CTL_A, 32'h0);
    event_in = '0;
    rd(O_LO_A, v); chk("R12 write edge timing", v, 32'd5);

    // R4: clear honoured only when stopped
    wr(O_CTL_A, 32'h0000_A001);
    rd(O_LO_A, v); chk("R4 clear from stopped", v, 32'd0);
    hold(9'b1, 2);
    wr(O_CTL_A, 32'h0000_A001);
    rd(O_LO_A, v); chk("R4 clear ignored running", v, 32'd2);
    wr(O_CTL_A, 32'h0000_2000);
    rd(O_LO_A, v); chk("R4 clear on stopping write ignored", v, 32'd2);
    wr(O_CTL_A, 32'h0000_2000);
    rd(O_LO_A, v); chk("R4 clear after stop", v, 32'd0);

    // R9: writes to count offsets and offset 0
    wr(O_CTL_A, 32'h0000_8001);
    hold(9'b1, 3);
    wr(O_CTL_A, 32'h0);
    wr(O_LO_A, 32'hFFFF_FFFF);
    wr(O_HI_A, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(O_LO_A, v);  chk("R9 lo unchanged", v, 32'd3);
    rd(O_HI_A, v);  chk("R9 hi unchanged", v, 32'd0);
    rd(O_CTL_A, v); chk("R9 ctl unchanged", v, 32'd0);

    // R8: aliasing of upper address bits, empty offsets
    rd(8'hB0, v); chk("R8 alias of low A", v, 32'd3);
    rd(8'h1C, v); chk("R8 unused offset", v, 32'd0);
    rd(8'hE0, v); chk("R8 offset zero", v, 32'd0);

    // R10 / R8: fill to all ones, wrap, sticky flag
    wr(O_CTL_A, 32'h0000_2000);
    wr(O_CTL_A, 32'h0000_8013);
    hold(9'b000100000, (1 << CNT_W) - 1);
    rd(O_LO_A, v);  chk("R8 low half at all ones", v, 32'h0000_00FF);
    rd(O_HI_A, v);  chk("R8 high half at all ones", v, 32'h0000_000F);
    rd(O_CTL_A, v); chk("R10 no overflow yet", v, 32'h0000_8013);
    hold(9'b000100000, 1);
    rd(O_LO_A, v);  chk("R10 wrap to zero", v, 32'h0);
    rd(O_HI_A, v);  chk("R10 wrap high zero", v, 32'h0);
    rd(O_CTL_A, v); chk("R10 overflow set", v, 32'h0000_C013);
    hold(9'b000100000, 3);
    wr(O_CTL_A, 32'h0);
    rd(O_CTL_A, v); chk("R10 overflow sticky", v, 32'h0000_4000);
    rd(O_LO_A, v);  chk("R10 count after wrap", v, 32'd3);
    wr(O_CTL_A, 32'h0000_2000);
    rd(O_CTL_A, v); chk("R10 overflow cleared", v, 32'h0);
    rd(O_LO_A, v);  chk("R4 count cleared", v, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule